// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block captures a stream of formatted trace words into an on-chip circular RAM. A formatter presents one word per cycle with a valid strobe. The block stores each accepted word at the current write index, and that index advances modulo the buffer depth. Capture continues through wrap-around, so the buffer always holds the most recent history. A trigger input arms a post-trigger counter. Once that many further words have been stored, capture halts and the block flags acquisition complete, which leaves a window of trace on both sides of the event.

A host reaches the block through a flat file of nine 32-bit registers using simple read and write strobes. The host clears the write index, loads the post-trigger count, and sets the enable bit. It then polls the status flags. To drain the buffer it sets the read index to the oldest valid entry and reads the data register repeatedly. Each read returns one stored word and steps the read index forward.

Top module: `tracebuf_ctrl`

## Requirements
- R1: Register selects are: 0 identification, 1 depth, 2 word width, 3 status, 4 RAM data, 5 read index, 6 write index, 7 post-trigger count, 8 control. Selects 9 to 15 read as zero. Depth and width read back the parameter values, and writes to them are ignored.
- R2: The identification register always reads the parameter ID_VALUE, and writes to it have no effect.
- R3: While control bit 0 is set, each formatter word with fmtValid high is stored at the write index. The write index then advances modulo DEPTH, one cycle after acceptance.
- R4: Control keeps only bits 1:0 (bit 0 enable, bit 1 demultiplexed-port select), and all other bits read as zero. Writing 0 to control stops capture, and later formatter words leave the write index unchanged.
- R5: Status bit 1 sets when trigIn is high while capture is enabled. After that, each accepted word decrements the post-trigger count. When the count is zero, no further word is accepted and status bit 2 (acquisition complete) sets.
- R6: Status bit 0 (wrapped) sets when a word is stored at index DEPTH-1. It stays set until the host writes the write-index register.
- R7: Reading the RAM data register returns the word at the read index, zero-extended, and then advances the read index modulo DEPTH. The read index is writable, with the value taken modulo DEPTH.
- R8: Status bit 3 (formatter empty) drops in the cycle after a word is accepted. It rises again one cycle after the last pending word has been written to RAM.
- R9: A control write that sets bit 0 while capture was disabled clears the trigger-seen and acquisition-complete flags.
- R10: After reset, status reads 0x8, and the control, read index and write index read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 4 | Register select |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect on RAM data) |
| regWrData | input | 32 | Register write value |
| regRdData | output | 32 | Register read value for regSel, combinational |
| fmtValid | input | 1 | Formatter word valid |
| fmtData | input | WIDTH | Formatter word |
| trigIn | input | 1 | Trigger event |

## Verification
A write index that is stored wrongly shows up in several places. The host reads back a wrong write-index value, the wrapped flag is set or clear when it should not be, and the drained words come back rotated or stale. All of this is visible one cycle after the last commit. A counting error in the post-trigger counter changes how many words are stored after the trigger. That appears as a wrong final write index and wrong counter and status values as soon as capture halts. A read-index error shows up on the very next data read as a word out of sequence.

// File: rtl/tracebuf_pkg.sv
package tracebuf_pkg;
  localparam logic [3:0] SEL_IDENT = 4'd0;
  localparam logic [3:0] SEL_DEPTH = 4'd1;
  localparam logic [3:0] SEL_WIDTH = 4'd2;
  localparam logic [3:0] SEL_STAT  = 4'd3;
  localparam logic [3:0] SEL_DATA  = 4'd4;
  localparam logic [3:0] SEL_RDPTR = 4'd5;
  localparam logic [3:0] SEL_WRPTR = 4'd6;
  localparam logic [3:0] SEL_TCNT  = 4'd7;
  localparam logic [3:0] SEL_CTRL  = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic stageLoad;  // capture formatter word into staging register
    logic commit;     // write staged word into RAM at write index
  } tb_strobe_t;
endpackage

// File: rtl/tracebuf_dp.sv
module tracebuf_dp #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tracebuf_pkg::tb_strobe_t stb,
  input  logic [WIDTH-1:0]        fmtData,
  input  logic [AW-1:0]           wrIdx,
  input  logic [AW-1:0]           rdIdx,
  output logic [WIDTH-1:0]        rdWord
);
  logic [WIDTH-1:0] stageData;
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageData <= '0;
    else if (stb.stageLoad) stageData <= fmtData;
  end

  always_ff @(posedge clk) begin
    if (stb.commit) mem[wrIdx] <= stageData;
  end

  assign rdWord = mem[rdIdx];
endmodule

// File: rtl/tracebuf_ctl.sv
module tracebuf_ctl #(
  parameter int          DEPTH    = 16,
  parameter int          WIDTH    = 24,
  parameter logic [31:0] ID_VALUE = 32'h7B10_0A01,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [3:0]               regSel,
  input  logic                     regWrEn,
  input  logic                     regRdEn,
  input  logic [31:0]              regWrData,
  output logic [31:0]              regRdData,
  input  logic                     fmtValid,
  input  logic                     trigIn,
  input  logic [WIDTH-1:0]         ramWord,
  output tracebuf_pkg::tb_strobe_t stb,
  output logic [AW-1:0]            wrIdx,
  output logic [AW-1:0]            rdIdx,
  output logic                     fullFlag,
  output logic                     trigSeen,
  output logic                     acqDone,
  output logic                     dfEmpty
);
  import tracebuf_pkg::*;

  logic [1:0]  ctrlReg;
  logic [31:0] postCnt;
  logic        stageValid;
  logic        accept;
  logic        haltCond;
  logic        wrCtrl, wrWp, wrRp, wrCnt, rdData;
  logic        armEdge;
  logic [31:0] ramWord32;
  logic [AW-1:0] wrIdxNext, rdIdxNext;

  generate
    if (WIDTH == 32) begin : g_full
      assign ramWord32 = ramWord;
    end else begin : g_pad
      assign ramWord32 = {{(32-WIDTH){1'b0}}, ramWord};
    end
  endgenerate

  assign wrCtrl  = regWrEn && (regSel == SEL_CTRL);
  assign wrWp    = regWrEn && (regSel == SEL_WRPTR);
  assign wrRp    = regWrEn && (regSel == SEL_RDPTR);
  assign wrCnt   = regWrEn && (regSel == SEL_TCNT);
  assign rdData  = regRdEn && !regWrEn && (regSel == SEL_DATA);
  assign armEdge = wrCtrl && regWrData[0] && !ctrlReg[0];

  assign haltCond = trigSeen && (postCnt == 32'd0);
  assign accept   = ctrlReg[0] && fmtValid && !haltCond && !acqDone;

  assign stb.stageLoad = accept;
  assign stb.commit    = stageValid;

  assign wrIdxNext = (wrIdx == AW'(DEPTH-1)) ? '0 : wrIdx + 1'b1;
  assign rdIdxNext = (rdIdx == AW'(DEPTH-1)) ? '0 : rdIdx + 1'b1;

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (wrCtrl) ctrlReg <= regWrData[1:0];
  end

  // staging pipeline and formatter-empty flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      dfEmpty    <= 1'b1;
    end else begin
      stageValid <= accept;
      dfEmpty    <= !accept && !stageValid;
    end
  end

  // write index and wrapped flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx    <= '0;
      fullFlag <= 1'b0;
    end else if (wrWp) begin
      wrIdx    <= regWrData[AW-1:0];
      fullFlag <= 1'b0;
    end else if (stageValid) begin
      wrIdx <= wrIdxNext;
      if (wrIdx == AW'(DEPTH-1)) fullFlag <= 1'b1;
    end
  end

  // read index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdIdx <= '0;
    else if (wrRp) rdIdx <= regWrData[AW-1:0];
    else if (rdData) rdIdx <= rdIdxNext;
  end

  // trigger, post-trigger count, completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigSeen <= 1'b0;
      acqDone  <= 1'b0;
      postCnt  <= '0;
    end else begin
      if (armEdge) trigSeen <= 1'b0;
      else if (ctrlReg[0] && trigIn) trigSeen <= 1'b1;

      if (armEdge) acqDone <= 1'b0;
      else if (ctrlReg[0] && haltCond) acqDone <= 1'b1;

      if (wrCnt) postCnt <= regWrData;
      else if (accept && trigSeen && postCnt != 32'd0) postCnt <= postCnt - 32'd1;
    end
  end

  // read mux
  always_comb begin
    unique case (regSel)
      SEL_IDENT: regRdData = ID_VALUE;
      SEL_DEPTH: regRdData = 32'(DEPTH);
      SEL_WIDTH: regRdData = 32'(WIDTH);
      SEL_STAT:  regRdData = {28'd0, dfEmpty, acqDone, trigSeen, fullFlag};
      SEL_DATA:  regRdData = ramWord32;
      SEL_RDPTR: regRdData = 32'(rdIdx);
      SEL_WRPTR: regRdData = 32'(wrIdx);
      SEL_TCNT:  regRdData = postCnt;
      SEL_CTRL:  regRdData = {30'd0, ctrlReg};
      default:   regRdData = 32'd0;
    endcase
  end
endmodule

// File: rtl/tracebuf_ctrl.sv
module tracebuf_ctrl #(
  parameter int          DEPTH    = 16,
  parameter int          WIDTH    = 24,
  parameter logic [31:0] ID_VALUE = 32'h7B10_0A01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       regSel,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             fmtValid,
  input  logic [WIDTH-1:0] fmtData,
  input  logic             trigIn
);
  localparam int AW = $clog2(DEPTH);

  tracebuf_pkg::tb_strobe_t stb;
  logic [AW-1:0]    wrIdx, rdIdx;
  logic [WIDTH-1:0] ramWord;
  logic             fullFlag, trigSeen, acqDone, dfEmpty;

  tracebuf_ctl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ID_VALUE(ID_VALUE)) u_ctl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .fmtValid(fmtValid), .trigIn(trigIn),
    .ramWord(ramWord), .stb(stb), .wrIdx(wrIdx), .rdIdx(rdIdx), .fullFlag(fullFlag),
    .trigSeen(trigSeen), .acqDone(acqDone), .dfEmpty(dfEmpty)
  );

  tracebuf_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .fmtData(fmtData),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .rdWord(ramWord)
  );
endmodule

// File: rtl/tracebuf_chk.sv
module tracebuf_chk #(
  parameter int          DEPTH    = 16,
  parameter logic [31:0] ID_VALUE = 32'h7B10_0A01,
  localparam int AW = $clog2(DEPTH)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [3:0]               regSel,
  input logic                     regWrEn,
  input logic                     regRdEn,
  input logic [31:0]              regRdData,
  input tracebuf_pkg::tb_strobe_t stb,
  input logic [AW-1:0]            wrIdx,
  input logic [AW-1:0]            rdIdx,
  input logic                     fullFlag,
  input logic                     acqDone,
  input logic                     dfEmpty
);
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 4'd0) |-> (regRdData == ID_VALUE)); // R2

  AST_WP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !(regWrEn && regSel == 4'd6)) |=>
      (wrIdx == (($past(wrIdx) == AW'(DEPTH-1)) ? '0 : $past(wrIdx) + 1'b1))); // R3

  AST_HALT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    acqDone |-> !stb.stageLoad); // R5

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && !(regWrEn && regSel == 4'd6)) |=> fullFlag); // R6

  AST_RP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && regSel == 4'd4) |=>
      (rdIdx == (($past(rdIdx) == AW'(DEPTH-1)) ? '0 : $past(rdIdx) + 1'b1))); // R7

  AST_EMPTY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    stb.stageLoad |=> !dfEmpty); // R8
endmodule

bind tracebuf_ctrl tracebuf_chk #(.DEPTH(DEPTH), .ID_VALUE(ID_VALUE)) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regRdData(regRdData), .stb(stb), .wrIdx(wrIdx), .rdIdx(rdIdx),
  .fullFlag(fullFlag), .acqDone(acqDone), .dfEmpty(dfEmpty)
);

// File: tb/tracebuf_ctrl_tb.sv
module tracebuf_ctrl_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          DEPTH      = 16;
  localparam int          WIDTH      = 24;
  localparam logic [31:0] IDV        = 32'h7B10_0A01;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regSel = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic fmtValid = 1'b0;
  logic [WIDTH-1:0] fmtData = '0;
  logic trigIn = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tracebuf_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ID_VALUE(IDV)) u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .fmtValid(fmtValid),
    .fmtData(fmtData), .trigIn(trigIn)
  );

  typedef struct packed {
    logic        isRead;
    logic [3:0]  sel;
    logic [31:0] val;
  } vec_t;

  localparam int NV = 16;
  // register-file vectors: R1, R2, R4, R7
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd0, IDV},            // R2 id
    '{1'b1, 4'd1, 32'(DEPTH)},     // R1 depth
    '{1'b1, 4'd2, 32'(WIDTH)},     // R1 width
    '{1'b0, 4'd0, 32'hFFFF_FFFF},
    '{1'b1, 4'd0, IDV},            // R2 write ignored
    '{1'b0, 4'd1, 32'h0000_0003},
    '{1'b1, 4'd1, 32'(DEPTH)},     // R1 depth read-only
    '{1'b1, 4'd12, 32'h0},         // R1 unused select
    '{1'b0, 4'd5, 32'd5},
    '{1'b1, 4'd5, 32'd5},          // R7 read index
    '{1'b0, 4'd5, 32'd20},
    '{1'b1, 4'd5, 32'd4},          // R7 modulo depth
    '{1'b0, 4'd7, 32'd7},
    '{1'b1, 4'd7, 32'd7},          // R1 count register
    '{1'b0, 4'd8, 32'hFFFF_FFFC},
    '{1'b1, 4'd8, 32'h0}           // R4 upper control bits dropped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] sel, input logic [31:0] val);
    @(negedge clk);
    regSel = sel; regWrData = val; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] sel, output logic [31:0] val);
    @(negedge clk);
    regSel = sel; regRdEn = 1'b1;
    #1 val = regRdData;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic pushWord(input logic [WIDTH-1:0] w, input logic trig);
    @(negedge clk);
    fmtValid = 1'b1; fmtData = w; trigIn = trig;
    @(posedge clk); #1;
    fmtValid = 1'b0; trigIn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    idle(3);
    rstN = 1'b1;

    // R10 reset state
    regRead(4'd3, rv); check("R10 status", rv, 32'h8);
    regRead(4'd8, rv); check("R10 control", rv, 32'h0);
    regRead(4'd5, rv); check("R10 read index", rv, 32'h0);
    regRead(4'd6, rv); check("R10 write index", rv, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRead) begin
        regRead(VECS[i].sel, rv);
        check($sformatf("R1/R2/R4/R7 vector %0d", i), rv, VECS[i].val);
      end else begin
        regWrite(VECS[i].sel, VECS[i].val);
      end
    end

    // R5 trigger + post-trigger count, no wrap
    regWrite(4'd6, 32'd0);
    regWrite(4'd7, 32'd3);
    regWrite(4'd8, 32'd1);
    for (int i = 0; i < 10; i++) pushWord(WIDTH'(32'h100 + i), i == 2);
    idle(3);
    regRead(4'd6, rv); check("R5 words stored after trigger", rv, 32'd6);
    regRead(4'd3, rv); check("R5 status trig+done", rv, 32'hE);
    regRead(4'd7, rv); check("R5 count exhausted", rv, 32'd0);
    regWrite(4'd5, 32'd0);
    for (int i = 0; i < 6; i++) begin
      regRead(4'd4, rv); check("R3/R7 drain linear", rv, 32'h100 + i);
    end
    regRead(4'd5, rv); check("R7 read index advanced", rv, 32'd6);

    // R9 re-arm, R8 formatter-empty timing, R6 wrap
    regWrite(4'd8, 32'd0);
    regWrite(4'd6, 32'd0);
    regWrite(4'd7, 32'd100);
    regWrite(4'd8, 32'd1);
    regRead(4'd3, rv); check("R9 flags cleared on arm", rv, 32'h8);
    pushWord(WIDTH'(32'h200), 1'b0);
    regRead(4'd3, rv); check("R8 empty low after accept", rv & 32'h8, 32'h0);
    regRead(4'd3, rv); check("R8 empty low while commit", rv & 32'h8, 32'h0);
    regRead(4'd3, rv); check("R8 empty high after commit", rv & 32'h8, 32'h8);
    for (int i = 1; i < 20; i++) pushWord(WIDTH'(32'h200 + i), 1'b0);
    idle(3);
    regRead(4'd6, rv); check("R3 write index modulo", rv, 32'd4);
    regRead(4'd3, rv); check("R6 wrapped status", rv, 32'h9);
    regWrite(4'd5, 32'd4);
    for (int k = 0; k < 16; k++) begin
      regRead(4'd4, rv); check("R6/R7 drain oldest first", rv, 32'h204 + k);
    end
    regRead(4'd5, rv); check("R7 read index wrapped", rv, 32'd4);

    // R4 stop
    regWrite(4'd8, 32'd0);
    for (int i = 0; i < 3; i++) pushWord(WIDTH'(32'h300 + i), 1'b0);
    idle(3);
    regRead(4'd6, rv); check("R4 stopped capture", rv, 32'd4);
    regRead(4'd3, rv); check("R6 full sticky when stopped", rv & 32'h1, 32'h1);
    regWrite(4'd6, 32'd0);
    regRead(4'd3, rv); check("R6 full cleared by index write", rv & 32'h1, 32'h0);
    regWrite(4'd8, 32'd2);
    regRead(4'd8, rv); check("R4 port select readback", rv, 32'd2);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule